// File: doc/BRIEF.md
# Interrupting GPIO Port

This block is one general-purpose I/O port of between 6 and 16 pins, set by a parameter and controlled through a plain 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data. Each pin can be an output, taking its value from an output latch, or an input. Input pins go through a two-stage synchronizer. After that, each pin can raise a pending interrupt flag on a falling edge, a rising edge, either edge, a low level or a high level.

Each pending flag is cleared by writing a one to it. Each pin can be masked with a separate set port and a separate clear port. The masked pending flags are ORed into one interrupt line. A soft reset register returns every port register to its reset value while its bit is held at one.

Top module: `gpio_irq_port`

## Requirements
- R1: The direction register (word 2) drives `pin_oe`, where a bit of 1 makes the pin an output. The output latch (word 0) drives `pin_out`. Both outputs show a write from the clock edge that takes it.
- R2: Word 1 reads the pin inputs after a two-flop synchronizer. A change that is sampled at clock edge k is readable after edge k+1.
- R3: Each pin has a 3-bit trigger mode. Pins 0 to 7 use word 9, with the field of pin i at bits 4*i+2..4*i. Pins 8 to 15 use word 10, with the field of pin i at bits 4*(i-8)+2..4*(i-8). Bit 3 of every nibble reads as zero.
- R4: Edge modes use code 0 for falling, 1 for rising and 4 for both. Edges are found by comparing the synchronized value with its value one cycle earlier. The pending flag (word 4) is set at the edge after the synchronized value changes. Codes 5 to 7 never set a flag.
- R5: Level modes use code 2 for low and 3 for high. A level pin sets its flag on every cycle its level is active. After a clear, the flag sets again on the next cycle if the level is still active.
- R6: A pin sets its pending flag only while its enable bit (word 3) is 1. Clearing an enable bit does not remove a flag that is already set.
- R7: Writing 1 to a bit of word 6 clears that pin's pending flag, even when a trigger arrives in the same cycle. Zero bits have no effect. Word 6 reads as zero.
- R8: Writing 1 to a bit of word 7 masks that pin, and writing 1 to a bit of word 8 unmasks it. Zero bits leave the mask unchanged, and both words read the mask. Word 5 reads pending AND NOT mask. `irq` is the OR of word 5.
- R9: Bit 0 of word 11 is the soft reset bit. While it reads 1, every port register except word 11 is held at zero and writes to them are ignored. Writing 0 releases them.
- R10: Bits at and above PIN_COUNT in every per-pin register read zero, and so do the mode nibbles of pins that do not exist.
- R11: After the synchronous active-low reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Word address of the register |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | PIN_COUNT | Asynchronous pin inputs |
| pin_out | output | PIN_COUNT | Output latch value per pin |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest case to reach from the ports is a pending clear written while a level pin is still active. That case must show the flag low for exactly one cycle before it returns. The stimulus holds a pin at its active level, writes the clear, and reads word 4 on the first cycle after that write and again on the next one. A second case is a write to a port register made while the soft reset bit is held. The stimulus writes the direction register between the writes of 1 and 0 to word 11, then checks that both `pin_oe` and the readback are still zero. A behavioural reference model is compared with the outputs on every clock. A long run of random pin toggles, clears and mode changes covers trigger arrivals that coincide with bus writes.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the interrupting GPIO port: register word
// addresses, trigger mode codes and mode field geometry.
// Assumes a 4-bit word address and 32-bit data bus.
package gpio_irq_pkg;

    localparam int REG_AW     = 4;
    localparam int DATA_W     = 32;
    localparam int MODE_W     = 3;
    localparam int MODE_PITCH = 4;
    localparam int LANES      = DATA_W / MODE_PITCH;

    localparam logic [REG_AW-1:0] A_DOUT  = 4'd0;
    localparam logic [REG_AW-1:0] A_DIN   = 4'd1;
    localparam logic [REG_AW-1:0] A_DIR   = 4'd2;
    localparam logic [REG_AW-1:0] A_EN    = 4'd3;
    localparam logic [REG_AW-1:0] A_PEND  = 4'd4;
    localparam logic [REG_AW-1:0] A_MSTAT = 4'd5;
    localparam logic [REG_AW-1:0] A_ACK   = 4'd6;
    localparam logic [REG_AW-1:0] A_MSET  = 4'd7;
    localparam logic [REG_AW-1:0] A_MCLR  = 4'd8;
    localparam logic [REG_AW-1:0] A_MLO   = 4'd9;
    localparam logic [REG_AW-1:0] A_MHI   = 4'd10;
    localparam logic [REG_AW-1:0] A_SRST  = 4'd11;

    typedef enum logic [MODE_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer for the pin inputs, plus one more stage that
// holds the synchronized value from the previous cycle for edge compare.
// Assumes the pins are asynchronous to clk; each bit is treated alone.
module gpio_in_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced,
    output logic [WIDTH-1:0] delayed
);

    logic [WIDTH-1:0] meta_q;

    // Shift the raw pins through the meta, sync and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q  <= '0;
            synced  <= '0;
            delayed <= '0;
        end else begin
            meta_q  <= raw;
            synced  <= meta_q;
            delayed <= synced;
        end
    end

endmodule

// File: rtl/gpio_trig_detect.sv
// Per-pin trigger decode: from the current and previous synchronized
// values and the pin's 3-bit mode, flags a trigger this cycle.
// Assumes modes are packed flat, MODE_W bits per pin, pin 0 lowest.
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]        cur,
    input  logic [WIDTH-1:0]        prev,
    input  logic [WIDTH*MODE_W-1:0] modes,
    output logic [WIDTH-1:0]        trig
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        trig_mode_e mode;
        assign mode = trig_mode_e'(modes[g*MODE_W +: MODE_W]);

        // Decide whether this pin's condition holds in this cycle.
        always_comb begin
            case (mode)
                TRIG_FALL: trig[g] = !cur[g] && prev[g];
                TRIG_RISE: trig[g] = cur[g] && !prev[g];
                TRIG_LOW:  trig[g] = !cur[g];
                TRIG_HIGH: trig[g] = cur[g];
                TRIG_BOTH: trig[g] = cur[g] ^ prev[g];
                default:   trig[g] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_port.sv
// Interrupting GPIO port: register file, pending/mask logic, mode
// storage and read mux. One combined interrupt out.
// Assumes 6 <= PIN_COUNT <= 16 and single-cycle bus writes.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PIN_COUNT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_AW-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq
);

    localparam int MODE_BITS = PIN_COUNT * MODE_W;
    localparam int PAD_W     = DATA_W - PIN_COUNT;

    logic [PIN_COUNT-1:0] dout_q, dir_q, en_q, pend_q, mask_q;
    logic [PIN_COUNT-1:0] pend_nx, mask_nx, mstat;
    logic [PIN_COUNT-1:0] pin_sync, pin_prev, trig;
    logic [PIN_COUNT-1:0] wlow, ack_bits;
    logic [MODE_BITS-1:0] mode_q, mode_nx;
    logic [DATA_W-1:0]    mlo_rd, mhi_rd;
    logic                 srst_q, wr_ok, unused_wdata;

    assign wlow         = bus_wdata[PIN_COUNT-1:0];
    assign wr_ok        = bus_wr && !srst_q;
    assign unused_wdata = ^bus_wdata;

    gpio_in_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (pin_in),
        .synced  (pin_sync),
        .delayed (pin_prev)
    );

    gpio_trig_detect #(.WIDTH(PIN_COUNT)) u_detect (
        .cur   (pin_sync),
        .prev  (pin_prev),
        .modes (mode_q),
        .trig  (trig)
    );

    // Pending: enabled triggers set, acknowledge bits win over sets.
    always_comb begin
        ack_bits = (wr_ok && bus_addr == A_ACK) ? wlow : '0;
        pend_nx  = (pend_q | (en_q & trig)) & ~ack_bits;
        mask_nx  = mask_q;
        if (wr_ok && bus_addr == A_MSET) mask_nx = mask_q | wlow;
        if (wr_ok && bus_addr == A_MCLR) mask_nx = mask_q & ~wlow;
    end

    // Mode field update per pin, lane chosen by the pin's register half.
    for (genvar g = 0; g < PIN_COUNT; g++) begin : g_mode
        localparam int LANE = g % LANES;
        logic lane_wr;
        if (g < LANES) begin : g_lo
            assign lane_wr = wr_ok && bus_addr == A_MLO;
        end else begin : g_hi
            assign lane_wr = wr_ok && bus_addr == A_MHI;
        end
        assign mode_nx[g*MODE_W +: MODE_W] = lane_wr
            ? bus_wdata[LANE*MODE_PITCH +: MODE_W]
            : mode_q[g*MODE_W +: MODE_W];
    end

    // Register file update; soft reset holds all port state at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || srst_q) begin
            dout_q <= '0;
            dir_q  <= '0;
            en_q   <= '0;
            pend_q <= '0;
            mask_q <= '0;
            mode_q <= '0;
        end else begin
            if (bus_wr && bus_addr == A_DOUT) dout_q <= wlow;
            if (bus_wr && bus_addr == A_DIR)  dir_q  <= wlow;
            if (bus_wr && bus_addr == A_EN)   en_q   <= wlow;
            pend_q <= pend_nx;
            mask_q <= mask_nx;
            mode_q <= mode_nx;
        end
    end

    // Soft reset bit, only cleared by the hard reset or a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)                             srst_q <= 1'b0;
        else if (bus_wr && bus_addr == A_SRST)  srst_q <= bus_wdata[0];
    end

    // Pack the mode fields into nibbles for readback; absent pins are zero.
    for (genvar k = 0; k < LANES; k++) begin : g_pack
        if (k < PIN_COUNT) begin : g_lo_on
            assign mlo_rd[k*MODE_PITCH +: MODE_PITCH] = {1'b0, mode_q[k*MODE_W +: MODE_W]};
        end else begin : g_lo_off
            assign mlo_rd[k*MODE_PITCH +: MODE_PITCH] = '0;
        end
        if (k + LANES < PIN_COUNT) begin : g_hi_on
            assign mhi_rd[k*MODE_PITCH +: MODE_PITCH] = {1'b0, mode_q[(k+LANES)*MODE_W +: MODE_W]};
        end else begin : g_hi_off
            assign mhi_rd[k*MODE_PITCH +: MODE_PITCH] = '0;
        end
    end

    assign mstat = pend_q & ~mask_q;

    // Read mux, per-pin words padded with zero above PIN_COUNT.
    always_comb begin
        case (bus_addr)
            A_DOUT:         bus_rdata = {{PAD_W{1'b0}}, dout_q};
            A_DIN:          bus_rdata = {{PAD_W{1'b0}}, pin_sync};
            A_DIR:          bus_rdata = {{PAD_W{1'b0}}, dir_q};
            A_EN:           bus_rdata = {{PAD_W{1'b0}}, en_q};
            A_PEND:         bus_rdata = {{PAD_W{1'b0}}, pend_q};
            A_MSTAT:        bus_rdata = {{PAD_W{1'b0}}, mstat};
            A_MSET, A_MCLR: bus_rdata = {{PAD_W{1'b0}}, mask_q};
            A_MLO:          bus_rdata = mlo_rd;
            A_MHI:          bus_rdata = mhi_rd;
            A_SRST:         bus_rdata = {{(DATA_W-1){1'b0}}, srst_q};
            default:        bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
    assign irq     = |mstat;

    // R1: a direction write reaches pin_oe at the next edge.
    p_dir_to_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !srst_q && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata[PIN_COUNT-1:0]));

    // R6: no pending bit rises unless its enable was set.
    p_pend_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R7: acknowledged bits are low right after the write.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !srst_q && bus_addr == A_ACK) |=> (pend_q & $past(bus_wdata[PIN_COUNT-1:0])) == '0);

    // R8: mask-set bits are all masked after the write.
    p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !srst_q && bus_addr == A_MSET) |=>
        (mask_q & $past(bus_wdata[PIN_COUNT-1:0])) == $past(bus_wdata[PIN_COUNT-1:0]));

    // R9: while soft reset is held, the port state is zero next cycle.
    p_srst_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (pend_q == '0 && en_q == '0 && dir_q == '0 && mask_q == '0 && !irq));

endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;

    localparam int N = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [3:0]     addr = '0;
    logic           wr = 1'b0;
    logic [31:0]    wdata = '0;
    logic [N-1:0]   pin_in = '0;
    wire  [31:0]    rdata;
    wire  [N-1:0]   pin_out, pin_oe;
    wire            irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    gpio_irq_port #(.PIN_COUNT(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state
    logic [N-1:0] m_dout, m_dir, m_en, m_pend, m_mask, m_s1, m_s2, m_s3, m_trig, m_pn;
    logic [2:0]   m_mode [N];
    logic         m_srst;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout = '0; m_dir = '0; m_en = '0; m_pend = '0; m_mask = '0;
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_srst = 1'b0;
            for (int i = 0; i < N; i++) m_mode[i] = 3'd0;
        end else begin
            for (int i = 0; i < N; i++) begin
                case (m_mode[i])
                    3'd0: m_trig[i] = !m_s2[i] && m_s3[i];
                    3'd1: m_trig[i] = m_s2[i] && !m_s3[i];
                    3'd2: m_trig[i] = !m_s2[i];
                    3'd3: m_trig[i] = m_s2[i];
                    3'd4: m_trig[i] = m_s2[i] != m_s3[i];
                    default: m_trig[i] = 1'b0;
                endcase
            end
            if (m_srst) begin
                m_dout = '0; m_dir = '0; m_en = '0; m_pend = '0; m_mask = '0;
                for (int i = 0; i < N; i++) m_mode[i] = 3'd0;
            end else begin
                m_pn = m_pend | (m_en & m_trig);
                if (wr) begin
                    case (addr)
                        4'd0: m_dout = wdata[N-1:0];
                        4'd2: m_dir  = wdata[N-1:0];
                        4'd3: m_en   = wdata[N-1:0];
                        4'd6: m_pn   = m_pn & ~wdata[N-1:0];
                        4'd7: m_mask = m_mask | wdata[N-1:0];
                        4'd8: m_mask = m_mask & ~wdata[N-1:0];
                        4'd9: for (int i = 0; i < 8 && i < N; i++) m_mode[i] = wdata[4*i +: 3];
                        4'd10: for (int i = 8; i < N; i++) m_mode[i] = wdata[4*(i-8) +: 3];
                        default: ;
                    endcase
                end
                m_pend = m_pn;
            end
            if (wr && addr == 4'd11) m_srst = wdata[0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    function automatic logic [31:0] mrd(input logic [3:0] a);
        logic [31:0] v;
        v = '0;
        case (a)
            4'd0: v[N-1:0] = m_dout;
            4'd1: v[N-1:0] = m_s2;
            4'd2: v[N-1:0] = m_dir;
            4'd3: v[N-1:0] = m_en;
            4'd4: v[N-1:0] = m_pend;
            4'd5: v[N-1:0] = m_pend & ~m_mask;
            4'd7, 4'd8: v[N-1:0] = m_mask;
            4'd9: for (int i = 0; i < 8 && i < N; i++) v[4*i +: 3] = m_mode[i];
            4'd10: for (int i = 8; i < N; i++) v[4*(i-8) +: 3] = m_mode[i];
            4'd11: v[0] = m_srst;
            default: ;
        endcase
        return v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of the pin outputs (R1) and the interrupt (R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 pin_oe", {{(32-N){1'b0}}, pin_oe}, {{(32-N){1'b0}}, m_dir});
            check("R1 pin_out", {{(32-N){1'b0}}, pin_out}, {{(32-N){1'b0}}, m_dout});
            check("R8 irq", {31'd0, irq}, {31'd0, |(m_pend & ~m_mask)});
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        addr = a; wr = 1'b1; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        @(negedge clk); #1;
        addr = a; #1;
        check(tag, rdata, mrd(a));
    endtask

    task automatic rd_exp(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        addr = a; #1;
        check(tag, rdata, exp);
    endtask

    task automatic set_pins(input logic [N-1:0] v);
        @(negedge clk); #1;
        pin_in = v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #100us;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;

        // R11: reset values
        for (int a = 0; a < 12; a++) rd_exp(a[3:0], 32'd0, "R11 reset read");

        // R1 / R10: direction and output latch, upper bits zero
        wr_reg(4'd2, 32'h0000_0A5A);
        wr_reg(4'd0, 32'hFFFF_FFFF);
        rd_exp(4'd0, 32'h0000_0FFF, "R10 dout upper zero");
        rd_exp(4'd2, 32'h0000_0A5A, "R1 dir readback");

        // R2: synchronizer latency
        set_pins(12'h3C3);
        rd_exp(4'd1, 32'h0, "R2 din not yet");
        rd_exp(4'd1, 32'h3C3, "R2 din after two flops");

        // R3 / R10: mode packing
        wr_reg(4'd9, 32'hFFFF_FFFF);
        rd_exp(4'd9, 32'h7777_7777, "R3 mode lo nibbles");
        wr_reg(4'd10, 32'hFFFF_FFFF);
        rd_exp(4'd10, 32'h0000_7777, "R10 mode hi absent pins");

        // Trigger tests: pin0 fall, pin1 rise, pin2 both, pin3 low, pin4 high, pin5 code 5
        set_pins(12'h008);
        wr_reg(4'd9, 32'h1153_2410);
        wr_reg(4'd10, 32'h0);
        rd_exp(4'd9, 32'h1153_2410, "R3 mode lo readback");
        idle(3);
        wr_reg(4'd6, 32'hFFF);
        wr_reg(4'd3, 32'h03F);
        set_pins(12'h0CF);
        idle(3);
        rd_exp(4'd4, 32'h006, "R4 rise and both edges");
        rd_chk(4'd4, "R6 pins 6 7 not enabled");
        set_pins(12'h008);
        idle(3);
        rd_exp(4'd4, 32'h007, "R4 falling edge");
        set_pins(12'h018);
        idle(3);
        rd_exp(4'd4, 32'h017, "R5 high level");
        set_pins(12'h010);
        idle(3);
        rd_exp(4'd4, 32'h01F, "R5 low level");

        // R7: zero writes do nothing, ones clear; R5 re-assert
        wr_reg(4'd6, 32'h0);
        rd_exp(4'd4, 32'h01F, "R7 zero ack no effect");
        wr_reg(4'd6, 32'h00A);
        rd_exp(4'd4, 32'h015, "R7 ack clears");
        rd_exp(4'd4, 32'h01D, "R5 level re-asserts");
        rd_exp(4'd6, 32'h0, "R7 ack reads zero");

        // R6: disabling does not drop pending
        wr_reg(4'd3, 32'h0);
        rd_exp(4'd4, 32'h01D, "R6 pending kept");

        // R8: mask set and clear
        wr_reg(4'd7, 32'h01F);
        rd_exp(4'd5, 32'h0, "R8 all masked");
        wr_reg(4'd8, 32'h004);
        rd_exp(4'd5, 32'h004, "R8 unmask one");
        wr_reg(4'd8, 32'h0);
        rd_exp(4'd7, 32'h01B, "R8 zero clear no effect");

        // R9: soft reset, writes ignored while held
        wr_reg(4'd11, 32'h1);
        wr_reg(4'd2, 32'hFFF);
        rd_exp(4'd11, 32'h1, "R9 srst reads one");
        wr_reg(4'd11, 32'h0);
        for (int a = 0; a < 12; a++) if (a != 1) rd_exp(a[3:0], 32'd0, "R9 srst cleared");

        // Random traffic compared with the model
        wr_reg(4'd3, 32'hFFF);
        for (int k = 0; k < 400; k++) begin
            case ($urandom % 5)
                0, 1: set_pins(N'($urandom));
                2: wr_reg(4'd6, $urandom);
                3: wr_reg((($urandom % 2) == 0) ? 4'd9 : 4'd10, $urandom);
                default: rd_chk(4'd4, "R4 random pending");
            endcase
            if (k % 7 == 0) rd_chk(4'd5, "R8 random status");
            if (k % 11 == 0) rd_chk(4'd1, "R2 random din");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule